// File: doc/BRIEF.md
# Debug Hart Handshake Region

This block is the small memory window that halted harts poll and write while they sit in the debug ROM loop. A hart reports that it is parked by writing its own id to a halt register. It learns what to do next by reading its byte in a flag array. It acknowledges a command by writing to a going or resuming register, and it reports a fault taken in debug mode through an exception register. A single instruction word, the jump slot, holds a `jal x0` that the block patches. The patched jump sends a hart that has been told to go into the abstract command ROM, the program buffer or the resume routine.

On the debugger side the block takes a halt request and a resume request for the hart named by `hartsel_i`. It also takes a go request from the abstract command logic, with a two-bit target selector. It returns per-hart halted, resume-acknowledge and halt-request lines, a busy flag and a one-cycle exception pulse. The hart-facing side is a single-beat slave bus. Writes take effect at the clock edge. Read data is registered and appears one cycle after the request, together with a valid strobe.

Top module: `dm_hart_handshake`

## Requirements
- R1: After reset, halted, resume-acknowledge, every flag bit and busy are zero, and the jump slot reads 0x00000013.
- R2: A bus write of hart id h to the halt register (0x100) sets halted[h]. The halt-request line of h is high while `haltreq_i` is set, `hartsel_i` equals h and h is not halted, so it drops in the cycle after that write.
- R3: The flag array starts at 0x400. The word at 0x400+4k carries hart 4k+b in byte lane b, with the go bit at bit 0 and the resume bit at bit 1. Bus writes into the array change nothing. Read data appears with `bus_rvalid_o` in the cycle after the read request.
- R4: A go request is taken only when the block is idle and the selected hart is halted. At the edge it is taken, the jump slot (0x300) is loaded with a `jal x0` to the chosen target: 0 for the abstract ROM, 1 for the program buffer, 2 or 3 for the resume routine. The offset is taken from the slot and encoded as imm[20|10:1|11|19:12] in bits 31:12 with opcode 0x6F. The go bit is set one edge later, never at the same edge.
- R5: Busy rises together with the go bit. It stays high until the going hart writes its id to the halt register after its going write. Go requests that arrive while busy change neither the jump slot nor any flag.
- R6: A write to the going register (0x104) clears the go bit of the hart that was sent.
- R7: A resume request sets the resume bit of the selected hart and clears its resume-acknowledge, but only if that hart is halted. Otherwise it has no effect.
- R8: A write of hart id h to the resuming register (0x108) clears the resume bit and halted of h and sets its resume-acknowledge.
- R9: A write to the exception register (0x10C) raises `exc_o` for exactly one cycle, and busy stays high until the hart is back in its halt loop.
- R10: `impebreak_o` reports whether the hardware supplies the ebreak that ends a program buffer run.
- R11: Several harts may hold resume bits at once, while at most one go bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| haltreq_i | input | 1 | Halt request for the selected hart |
| resumereq_i | input | 1 | Resume request pulse for the selected hart |
| hartsel_i | input | HW | Selected hart index |
| go_req_i | input | 1 | Go request pulse from abstract command logic |
| go_tgt_i | input | 2 | Jump target: 0 abstract ROM, 1 program buffer, 2/3 resume |
| bus_req_i | input | 1 | Bus request from a hart |
| bus_we_i | input | 1 | Bus write enable |
| bus_addr_i | input | AW | Byte address within the region |
| bus_wdata_i | input | 32 | Write data (hart id for handshake registers) |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after request |
| halted_o | output | NHARTS | Per-hart halted status |
| resumeack_o | output | NHARTS | Per-hart resume acknowledge |
| halt_req_o | output | NHARTS | Per-hart halt request line |
| busy_o | output | 1 | A go command is outstanding |
| exc_o | output | 1 | One-cycle pulse on an exception report |
| impebreak_o | output | 1 | Implicit ebreak after the program buffer |

## Verification
The bench checks the jump slot in the cycle between the slot load and the go bit. A design that set go at the same edge would let a hart take a stale jump, and the bench sees busy already high there. It sends go requests while busy and toward an unhalted hart. A design that failed to ignore them would repatch the slot or raise go. It issues resume requests to an unhalted hart and to two halted ones. A wrong design would set a stray resume bit or let one resume overwrite another. It also writes into the flag array to show that the bits do not move, and checks that the exception pulse lasts one cycle with busy held.

// File: rtl/dm_hart_handshake.sv
module dm_hart_handshake #(
  parameter int          NHARTS        = 4,
  parameter int          AW            = 12,
  parameter bit          IMPEBREAK     = 1'b1,
  parameter logic [31:0] HALTED_ADDR   = 32'h100,
  parameter logic [31:0] GOING_ADDR    = 32'h104,
  parameter logic [31:0] RESUMING_ADDR = 32'h108,
  parameter logic [31:0] EXC_ADDR      = 32'h10C,
  parameter logic [31:0] WHERETO_ADDR  = 32'h300,
  parameter logic [31:0] FLAGS_ADDR    = 32'h400,
  parameter logic [31:0] ABS_ADDR      = 32'h338,
  parameter logic [31:0] PBUF_ADDR     = 32'h360,
  parameter logic [31:0] RESUME_ADDR   = 32'h804,
  localparam int         HW            = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              haltreq_i,
  input  logic              resumereq_i,
  input  logic [HW-1:0]     hartsel_i,
  input  logic              go_req_i,
  input  logic [1:0]        go_tgt_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [NHARTS-1:0] halted_o,
  output logic [NHARTS-1:0] resumeack_o,
  output logic [NHARTS-1:0] halt_req_o,
  output logic              busy_o,
  output logic              exc_o,
  output logic              impebreak_o
);
  localparam int          NW     = (NHARTS + 3) / 4;
  localparam logic [31:0] NOP    = 32'h0000_0013;
  localparam logic [AW-1:0] A_HLT = HALTED_ADDR[AW-1:0];
  localparam logic [AW-1:0] A_GO  = GOING_ADDR[AW-1:0];
  localparam logic [AW-1:0] A_RES = RESUMING_ADDR[AW-1:0];
  localparam logic [AW-1:0] A_EXC = EXC_ADDR[AW-1:0];
  localparam logic [AW-1:0] A_WT  = WHERETO_ADDR[AW-1:0];
  localparam logic [AW-1:0] A_FLG = FLAGS_ADDR[AW-1:0];
  localparam logic [AW-1:0] FSPAN = AW'(NW * 4);

  function automatic logic [31:0] jal_x0(input logic [31:0] tgt);
    logic [31:0] off;
    off = tgt - WHERETO_ADDR;
    return {off[20], off[10:1], off[11], off[19:12], 5'd0, 7'b1101111};
  endfunction

  logic [NHARTS-1:0] halted_q, rack_q, go_q, rs_q;
  logic [31:0]       whereto_q, rdata_q, flag_word, rdata_d;
  logic              go_pend, gone_q, busy_q, exc_q, rvalid_q;
  logic [HW-1:0]     go_hart;

  wire wr = bus_req_i & bus_we_i;
  wire rd = bus_req_i & ~bus_we_i;
  wire wr_halted = wr && bus_addr_i == A_HLT;
  wire wr_going  = wr && bus_addr_i == A_GO;
  wire wr_resum  = wr && bus_addr_i == A_RES;
  wire wr_exc    = wr && bus_addr_i == A_EXC;
  wire [HW-1:0] wid = bus_wdata_i[HW-1:0];
  wire wid_ok = bus_wdata_i < 32'(NHARTS);
  wire sel_ok = 32'(hartsel_i) < 32'(NHARTS);
  wire go_ok  = go_req_i & ~busy_q & ~go_pend & sel_ok & halted_q[hartsel_i];

  wire [AW-1:0] foff = bus_addr_i - A_FLG;
  wire in_flags = (bus_addr_i >= A_FLG) && (foff < FSPAN);

  always_comb begin
    flag_word = '0;
    for (int b = 0; b < 4; b++) begin
      int idx;
      idx = int'(foff[AW-1:2]) * 4 + b;
      if (idx < NHARTS) flag_word[8*b +: 8] = {6'd0, rs_q[idx], go_q[idx]};
    end
  end

  always_comb begin
    if (bus_addr_i == A_WT) rdata_d = whereto_q;
    else if (in_flags)      rdata_d = flag_word;
    else                    rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q  <= '0;
      rack_q    <= '0;
      go_q      <= '0;
      rs_q      <= '0;
      whereto_q <= NOP;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
      go_pend   <= 1'b0;
      gone_q    <= 1'b0;
      busy_q    <= 1'b0;
      exc_q     <= 1'b0;
      go_hart   <= '0;
    end else begin
      exc_q    <= wr_exc;
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;

      if (go_ok) begin
        case (go_tgt_i)
          2'd0:    whereto_q <= jal_x0(ABS_ADDR);
          2'd1:    whereto_q <= jal_x0(PBUF_ADDR);
          default: whereto_q <= jal_x0(RESUME_ADDR);
        endcase
        go_pend <= 1'b1;
        go_hart <= hartsel_i;
      end
      if (go_pend) begin
        go_q[go_hart] <= 1'b1;
        busy_q        <= 1'b1;
        gone_q        <= 1'b0;
        go_pend       <= 1'b0;
      end
      if (wr_going && busy_q) begin
        go_q[go_hart] <= 1'b0;
        gone_q        <= 1'b1;
      end
      if (wr_halted && wid_ok) begin
        halted_q[wid] <= 1'b1;
        if (busy_q && gone_q && wid == go_hart) busy_q <= 1'b0;
      end
      if (resumereq_i && sel_ok && halted_q[hartsel_i]) begin
        rs_q[hartsel_i]   <= 1'b1;
        rack_q[hartsel_i] <= 1'b0;
      end
      if (wr_resum && wid_ok) begin
        rs_q[wid]     <= 1'b0;
        halted_q[wid] <= 1'b0;
        rack_q[wid]   <= 1'b1;
      end
    end
  end

  for (genvar h = 0; h < NHARTS; h++) begin : g_hreq
    assign halt_req_o[h] = haltreq_i & sel_ok & (32'(hartsel_i) == h) & ~halted_q[h];
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign halted_o     = halted_q;
  assign resumeack_o  = rack_q;
  assign busy_o       = busy_q;
  assign exc_o        = exc_q;
  assign impebreak_o  = IMPEBREAK;
endmodule

// File: rtl/dm_hart_handshake_chk.sv
module dm_hart_handshake_chk #(
  parameter int          NHARTS        = 4,
  parameter int          AW            = 12,
  parameter logic [31:0] RESUMING_ADDR = 32'h108,
  localparam int         HW            = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NHARTS-1:0] go_q,
  input logic [NHARTS-1:0] rs_q,
  input logic [NHARTS-1:0] halted_o,
  input logic [NHARTS-1:0] resumeack_o,
  input logic [31:0]       whereto_q,
  input logic              busy_o,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [31:0]       bus_wdata_i
);
  // R11
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(go_q));

  // R4
  slot_before_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(go_q & ~$past(go_q))) |-> $stable(whereto_q));

  // R5
  busy_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|go_q) |-> busy_o);

  // R7
  resume_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_q & ~halted_o) == '0);

  // R8
  resuming_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && bus_we_i && bus_addr_i == RESUMING_ADDR[AW-1:0] && bus_wdata_i < 32'(NHARTS))
    |=> resumeack_o[$past(bus_wdata_i[HW-1:0])]);
endmodule

bind dm_hart_handshake dm_hart_handshake_chk #(
  .NHARTS(NHARTS), .AW(AW), .RESUMING_ADDR(RESUMING_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go_q(go_q), .rs_q(rs_q), .halted_o(halted_o),
  .resumeack_o(resumeack_o), .whereto_q(whereto_q), .busy_o(busy_o),
  .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i)
);

// File: tb/dm_hart_handshake_tb.sv
module dm_hart_handshake_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        haltreq = 0, resumereq = 0, go_req = 0;
  logic [1:0]  hartsel = 0, go_tgt = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rvalid, busy, exc, impeb;
  logic [3:0]  halted, rack, hreq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dm_hart_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .haltreq_i(haltreq), .resumereq_i(resumereq),
    .hartsel_i(hartsel), .go_req_i(go_req), .go_tgt_i(go_tgt),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .halted_o(halted),
    .resumeack_o(rack), .halt_req_o(hreq), .busy_o(busy), .exc_o(exc),
    .impebreak_o(impeb));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
    chk(rvalid === 1'b1, "R3 rvalid", 32'(rvalid), 1);
  endtask

  task automatic go(input logic [1:0] h, input logic [1:0] t);
    @(negedge clk); hartsel = h; go_tgt = t; go_req = 1;
    @(negedge clk); go_req = 0;
  endtask

  task automatic resume(input logic [1:0] h);
    @(negedge clk); hartsel = h; resumereq = 1;
    @(negedge clk); resumereq = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(halted === 0, "R1 halted", 32'(halted), 0);
    chk(rack === 0, "R1 resumeack", 32'(rack), 0);
    chk(busy === 0, "R1 busy", 32'(busy), 0);
    rd(12'h300, d); chk(d === 32'h13, "R1 whereto", d, 32'h13);
    rd(12'h400, d); chk(d === 0, "R1 flags", d, 0);
    chk(impeb === 1'b1, "R10 impebreak", 32'(impeb), 1);
  endtask

  task automatic t_halt;
    @(negedge clk); haltreq = 1; hartsel = 1;
    #1 chk(hreq === 4'b0010, "R2 halt request up", 32'(hreq), 32'h2);
    wr(12'h100, 1);
    chk(halted === 4'b0010, "R2 halted set", 32'(halted), 32'h2);
    chk(hreq === 4'b0000, "R2 halt request drops", 32'(hreq), 0);
    haltreq = 0;
    wr(12'h100, 0); wr(12'h100, 2);
    chk(halted === 4'b0111, "R2 three halted", 32'(halted), 32'h7);
  endtask

  task automatic t_go;
    logic [31:0] d;
    go(3, 0);
    repeat (2) @(negedge clk);
    chk(busy === 0, "R4 go to running hart ignored", 32'(busy), 0);
    go(1, 1);
    chk(busy === 0, "R4 go not set at slot edge", 32'(busy), 0);
    @(negedge clk);
    chk(busy === 1, "R5 busy with go", 32'(busy), 1);
    rd(12'h300, d); chk(d === 32'h0600006F, "R4 jal to program buffer", d, 32'h0600006F);
    rd(12'h400, d); chk(d === 32'h00000100, "R3 go bit of hart 1", d, 32'h100);
    go(2, 0);
    repeat (2) @(negedge clk);
    rd(12'h300, d); chk(d === 32'h0600006F, "R5 slot kept while busy", d, 32'h0600006F);
    rd(12'h400, d); chk(d === 32'h00000100, "R11 single go bit", d, 32'h100);
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, d); chk(d === 32'h00000100, "R3 flag write ignored", d, 32'h100);
    wr(12'h104, 0);
    rd(12'h400, d); chk(d === 0, "R6 going clears go", d, 0);
    chk(busy === 1, "R5 busy after going", 32'(busy), 1);
    wr(12'h10C, 0);
    chk(exc === 1, "R9 exception pulse", 32'(exc), 1);
    @(negedge clk);
    chk(exc === 0, "R9 pulse one cycle", 32'(exc), 0);
    chk(busy === 1, "R9 busy held after exception", 32'(busy), 1);
    wr(12'h100, 1);
    chk(busy === 0, "R5 busy clears on halted", 32'(busy), 0);
    go(0, 2);
    @(negedge clk);
    rd(12'h300, d); chk(d === 32'h5040006F, "R4 jal to resume", d, 32'h5040006F);
    wr(12'h104, 0); wr(12'h100, 0);
    chk(busy === 0, "R5 second go done", 32'(busy), 0);
  endtask

  task automatic t_resume;
    logic [31:0] d;
    resume(3);
    rd(12'h400, d); chk(d === 0, "R7 resume to running hart ignored", d, 0);
    resume(1); resume(2);
    rd(12'h400, d); chk(d === 32'h00020200, "R11 two resume bits", d, 32'h00020200);
    wr(12'h108, 1);
    chk(halted === 4'b0101, "R8 halted cleared", 32'(halted), 32'h5);
    chk(rack === 4'b0010, "R8 resumeack set", 32'(rack), 32'h2);
    rd(12'h400, d); chk(d === 32'h00020000, "R8 resume bit cleared", d, 32'h00020000);
    wr(12'h100, 1);
    resume(1);
    chk(rack === 4'b0000, "R7 resumeack cleared", 32'(rack), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_halt();
    t_go();
    t_resume();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule